// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division for a 64-bit core and keeps the results in two 64-bit registers, HI and LO. A single-cycle start strobe, together with an operation code and two operands, launches one of six operations. These are signed or unsigned multiply, signed or unsigned divide, and direct writes of a full 64-bit operand into HI or into LO. Each 32-bit result half is sign-extended to 64 bits before it is stored, and this applies to the unsigned operations as well. No arithmetic exception is ever raised. Division by zero and the single overflowing signed quotient each produce a fixed, defined result.

Multiplies and register writes finish at the edge that accepts them. A divide runs a radix-2 restoring loop on operand magnitudes for one iteration per bit, followed by one sign fix-up cycle, and holds `busy` for the whole run. A multiply also presents its new LO value for an optional write to a general register. The surrounding pipeline is responsible for interlocking on `busy`.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `hi` and `lo` are zero, and `busy`, `done` and `gprWrEn` are low.
- R2: Op code 0 (signed multiply) forms the 64-bit product of the signed low 32 bits of `opA` and `opB`. `lo` receives the sign-extended low product half and `hi` the sign-extended high half. `done` is high in the cycle after the accepting edge.
- R3: Op code 1 (unsigned multiply) treats both low 32-bit operands as unsigned. It stores the two product halves sign-extended, exactly as R2 does.
- R4: A multiply pulses `gprWrEn` together with `done`, and `gprWrData` then equals the new `lo`. No other op raises `gprWrEn`.
- R5: Op code 4 copies all 64 bits of `opA` into `hi`, and op code 5 copies them into `lo`. The other register keeps its value, and `done` pulses one cycle after the accepting edge.
- R6: Op code 2 (signed divide) puts the quotient, truncated toward zero, in `lo` and the remainder, which takes the dividend's sign, in `hi`. Both are sign-extended. `busy` is high from the accepting edge on, and `done` rises with `busy` low after the 34th rising edge, counting the accepting edge as the first.
- R7: Op code 3 (unsigned divide) treats the low 32-bit operands as unsigned. It stores the quotient and remainder sign-extended, with the same latency as R6.
- R8: A signed divide by zero sets `lo` to 1 when the dividend is negative and to all ones otherwise, and sets `hi` to the sign-extended dividend.
- R9: An unsigned divide by zero sets `lo` to all ones and `hi` to the sign-extended dividend.
- R10: A signed divide of 0x80000000 by 0xFFFFFFFF gives `lo` = 0xFFFFFFFF80000000 and `hi` = 0.
- R11: A `start` that arrives while `busy` is high is ignored. The running divide completes with its own result, and no extra `done` follows.
- R12: Op codes 6 and 7 are ignored. They produce no `done` and leave `hi` and `lo` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, accepted only while not busy |
| op | input | 3 | Operation code (0..5 valid) |
| opA | input | 64 | First operand / dividend / move source |
| opB | input | 64 | Second operand / divisor (low 32 bits used) |
| hi | output | 64 | HI result register |
| lo | output | 64 | LO result register |
| busy | output | 1 | A divide is in progress |
| done | output | 1 | One-cycle completion pulse |
| gprWrEn | output | 1 | Multiply result is offered for a register write |
| gprWrData | output | 64 | Value for that register write (the new LO) |

## Verification
Two activities can fall in the same cycle. The first is a divide's completion pulse and the acceptance of the next operation: the driver launches each operation in the very cycle where it sees `done`, so every result is followed immediately by a new start. The scoreboard then compares both results in order and checks each one's latency. The second is a new `start` landing in the middle of a running divide. The bench provokes it with a multiply request while `busy` is high, and judges it by the divide result arriving unaltered with no unmatched `done` afterwards.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [2:0] OP_MULS = 3'd0;
  localparam logic [2:0] OP_MULU = 3'd1;
  localparam logic [2:0] OP_DIVS = 3'd2;
  localparam logic [2:0] OP_DIVU = 3'd3;
  localparam logic [2:0] OP_MTHI = 3'd4;
  localparam logic [2:0] OP_MTLO = 3'd5;

  typedef struct packed {
    logic mulGo;
    logic mulSigned;
    logic mtHi;
    logic mtLo;
    logic divInit;
    logic divSigned;
    logic divStep;
    logic divFin;
  } strobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] op,
  output strobe_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       gprWrEn
);

  localparam int CW = $clog2(WORD);
  localparam logic [CW-1:0] LAST = CW'(WORD - 1);

  typedef enum logic [1:0] {S_IDLE, S_ITER, S_FIX} state_e;

  state_e        state;
  logic [CW-1:0] cnt;
  logic          accept;
  logic          isMul;
  logic          isDiv;
  logic          isMove;

  assign accept = start && (state == S_IDLE);
  assign isMul  = (op == OP_MULS) || (op == OP_MULU);
  assign isDiv  = (op == OP_DIVS) || (op == OP_DIVU);
  assign isMove = (op == OP_MTHI) || (op == OP_MTLO);
  assign busy   = (state != S_IDLE);

  always_comb begin
    ctl = '0;
    if (accept) begin
      ctl.mulGo     = isMul;
      ctl.mulSigned = (op == OP_MULS);
      ctl.mtHi      = (op == OP_MTHI);
      ctl.mtLo      = (op == OP_MTLO);
      ctl.divInit   = isDiv;
      ctl.divSigned = (op == OP_DIVS);
    end
    ctl.divStep = (state == S_ITER);
    ctl.divFin  = (state == S_FIX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      gprWrEn <= 1'b0;
    end else begin
      done    <= (accept && (isMul || isMove)) || (state == S_FIX);
      gprWrEn <= accept && isMul;
      case (state)
        S_IDLE: if (accept && isDiv) begin
          state <= S_ITER;
          cnt   <= '0;
        end
        S_ITER: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= S_FIX;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6: completion is never reported while still busy
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R11: a start during iteration never restarts the step counter
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ITER) |=> (state == S_FIX) || (cnt == $past(cnt) + 1'b1));

  // R4: register-write offer only accompanies a completion
  assert_gpr_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    gprWrEn |-> done);

  // R6: an accepted divide makes the unit busy on the next cycle
  assert_div_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divInit |=> busy);

endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int WORD  = 32,
  parameter int DWORD = 2 * WORD
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          ctl,
  input  logic [DWORD-1:0] opA,
  input  logic [DWORD-1:0] opB,
  output logic [DWORD-1:0] hi,
  output logic [DWORD-1:0] lo,
  output logic [DWORD-1:0] gprData
);

  function automatic logic [DWORD-1:0] sext(input logic [WORD-1:0] w);
    return {{(DWORD-WORD){w[WORD-1]}}, w};
  endfunction

  logic [WORD-1:0]  a32, b32;
  logic [DWORD-1:0] aExt, bExt, prod;
  logic             aNeg, bNeg;
  logic [WORD-1:0]  magA, magB;

  logic [WORD-1:0] remR, quoR, dsrR, dvdSave;
  logic            negQ, negR, zeroDiv, sgnDiv;

  logic [WORD:0]   shifted;
  logic [WORD+1:0] diff;
  logic [WORD-1:0] qFix, rFix;

  assign a32  = opA[WORD-1:0];
  assign b32  = opB[WORD-1:0];
  assign aExt = ctl.mulSigned ? sext(a32) : {{(DWORD-WORD){1'b0}}, a32};
  assign bExt = ctl.mulSigned ? sext(b32) : {{(DWORD-WORD){1'b0}}, b32};
  assign prod = aExt * bExt;

  assign aNeg = ctl.divSigned && a32[WORD-1];
  assign bNeg = ctl.divSigned && b32[WORD-1];
  assign magA = aNeg ? (~a32 + 1'b1) : a32;
  assign magB = bNeg ? (~b32 + 1'b1) : b32;

  assign shifted = {remR, quoR[WORD-1]};
  assign diff    = {1'b0, shifted} - {2'b00, dsrR};
  assign qFix    = negQ ? (~quoR + 1'b1) : quoR;
  assign rFix    = negR ? (~remR + 1'b1) : remR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hi      <= '0;
      lo      <= '0;
      gprData <= '0;
      remR    <= '0;
      quoR    <= '0;
      dsrR    <= '0;
      dvdSave <= '0;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      zeroDiv <= 1'b0;
      sgnDiv  <= 1'b0;
    end else begin
      if (ctl.mulGo) begin
        hi      <= sext(prod[DWORD-1:WORD]);
        lo      <= sext(prod[WORD-1:0]);
        gprData <= sext(prod[WORD-1:0]);
      end
      if (ctl.mtHi) hi <= opA;
      if (ctl.mtLo) lo <= opA;
      if (ctl.divInit) begin
        remR    <= '0;
        quoR    <= magA;
        dsrR    <= magB;
        dvdSave <= a32;
        negQ    <= aNeg ^ bNeg;
        negR    <= aNeg;
        zeroDiv <= (b32 == '0);
        sgnDiv  <= ctl.divSigned;
      end
      if (ctl.divStep) begin
        if (!diff[WORD+1]) begin
          remR <= diff[WORD-1:0];
          quoR <= {quoR[WORD-2:0], 1'b1};
        end else begin
          remR <= shifted[WORD-1:0];
          quoR <= {quoR[WORD-2:0], 1'b0};
        end
      end
      if (ctl.divFin) begin
        if (zeroDiv) begin
          lo <= (sgnDiv && dvdSave[WORD-1]) ? DWORD'(1) : '1;
          hi <= sext(dvdSave);
        end else begin
          lo <= sext(qFix);
          hi <= sext(rFix);
        end
      end
    end
  end

  // R2, R3, R6, R7: arithmetic results are always sign-extended halves
  assert_sext_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mulGo || ctl.divFin) |=>
      (hi[DWORD-1:WORD] == {(DWORD-WORD){hi[WORD-1]}}) &&
      (lo[DWORD-1:WORD] == {(DWORD-WORD){lo[WORD-1]}}));

  // R9: unsigned divide by zero leaves LO all ones
  assert_divu_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divFin && zeroDiv && !sgnDiv) |=> (lo == '1));

  // R4: the register-write value tracks the LO produced by a multiply
  assert_gpr_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mulGo |=> (gprData == lo));

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
  import muldiv_pkg::*;
#(
  parameter int WORD = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [2*WORD-1:0] opA,
  input  logic [2*WORD-1:0] opB,
  output logic [2*WORD-1:0] hi,
  output logic [2*WORD-1:0] lo,
  output logic              busy,
  output logic              done,
  output logic              gprWrEn,
  output logic [2*WORD-1:0] gprWrData
);

  localparam int DWORD = 2 * WORD;

  strobe_t ctl;

  muldiv_ctrl #(.WORD(WORD)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .op      (op),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .gprWrEn (gprWrEn)
  );

  muldiv_dp #(.WORD(WORD), .DWORD(DWORD)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .hi      (hi),
    .lo      (lo),
    .gprData (gprWrData)
  );

endmodule

// File: tb/muldiv_hilo_test.sv
`timescale 1ns/1ps
module muldiv_hilo_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [63:0] opA = '0, opB = '0;
  logic [63:0] hi, lo, gprWrData;
  logic        busy, done, gprWrEn;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [63:0] eHi;
    logic [63:0] eLo;
    logic        eGpr;
    string       tag;
  } exp_t;

  exp_t expQ[$];
  logic [63:0] lastHi = '0, lastLo = '0;

  always #2 clk = ~clk;

  muldiv_hilo uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .opA(opA), .opB(opB),
    .hi(hi), .lo(lo), .busy(busy), .done(done),
    .gprWrEn(gprWrEn), .gprWrData(gprWrData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] w);
    return {{32{w[31]}}, w};
  endfunction

  // monitor: pops one expectation per completion pulse
  always @(posedge clk) begin
    #1;
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R11/R12 unexpected done", 64'(done), 64'd0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(hi == e.eHi, {e.tag, " hi"}, hi, e.eHi);
        check(lo == e.eLo, {e.tag, " lo"}, lo, e.eLo);
        check(gprWrEn == e.eGpr, {e.tag, " R4 gprWrEn"}, 64'(gprWrEn), 64'(e.eGpr));
        if (e.eGpr) check(gprWrData == e.eLo, {e.tag, " R4 gprWrData"}, gprWrData, e.eLo);
        check(!busy, {e.tag, " R6 busy at done"}, 64'(busy), 64'd0);
      end
    end
  end

  // driver: computes expectation, launches, measures latency
  task automatic issue(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b,
                       input string tag, input bit poke);
    exp_t e;
    logic [31:0] a32, b32, q, r;
    logic [63:0] p;
    int n, lat;
    a32 = a[31:0];
    b32 = b[31:0];
    e.eHi = lastHi; e.eLo = lastLo; e.eGpr = 1'b0; e.tag = tag;
    lat = 1;
    case (o)
      3'd0: begin p = sx(a32) * sx(b32); e.eHi = sx(p[63:32]); e.eLo = sx(p[31:0]); e.eGpr = 1'b1; end
      3'd1: begin p = {32'd0, a32} * {32'd0, b32}; e.eHi = sx(p[63:32]); e.eLo = sx(p[31:0]); e.eGpr = 1'b1; end
      3'd2: begin
        lat = 34;
        if (b32 == 0) begin e.eLo = a32[31] ? 64'd1 : '1; e.eHi = sx(a32); end
        else if (a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) begin e.eLo = sx(a32); e.eHi = 64'd0; end
        else begin
          q = $signed(a32) / $signed(b32);
          r = $signed(a32) % $signed(b32);
          e.eLo = sx(q); e.eHi = sx(r);
        end
      end
      3'd3: begin
        lat = 34;
        if (b32 == 0) begin e.eLo = '1; e.eHi = sx(a32); end
        else begin e.eLo = sx(a32 / b32); e.eHi = sx(a32 % b32); end
      end
      3'd4: e.eHi = a;
      default: e.eLo = a;
    endcase
    lastHi = e.eHi; lastLo = e.eLo;
    expQ.push_back(e);
    op = o; opA = a; opB = b; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    n = 1;
    while (!done && n < 100) begin
      if (poke && n == 5) begin op = 3'd1; start = 1'b1; end
      else start = 1'b0;
      @(posedge clk); #1;
      n++;
    end
    start = 1'b0;
    check(n == lat, {tag, " latency"}, 64'(n), 64'(lat));
  endtask

  task automatic unusedOp(input logic [2:0] o);
    op = o; opA = 64'hDEAD_BEEF_0BAD_F00D; opB = 64'h5; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(!done, "R12 done on unused op", 64'(done), 64'd0);
      @(posedge clk); #1;
    end
    check(hi == lastHi, "R12 hi unchanged", hi, lastHi);
    check(lo == lastLo, "R12 lo unchanged", lo, lastLo);
  endtask

  initial begin
    #(4 * 100000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(hi == 0 && lo == 0, "R1 reset hi/lo", hi | lo, 64'd0);
    check(!busy && !done && !gprWrEn, "R1 reset flags", {61'd0, busy, done, gprWrEn}, 64'd0);
    rstN = 1'b1;
    @(posedge clk); #1;

    issue(3'd0, 64'hFFFF_FFFD, 64'd7, "R2 muls neg", 0);
    issue(3'd0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R2 muls max", 0);
    issue(3'd1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, "R3 mulu ones", 0);
    issue(3'd1, 64'h8000_0000, 64'd2, "R3 mulu carry", 0);
    issue(3'd4, 64'h1234_5678_9ABC_DEF0, 64'd0, "R5 mthi", 0);
    issue(3'd5, 64'hFEDC_BA98_7654_3210, 64'd0, "R5 mtlo", 0);
    issue(3'd2, 64'hFFFF_FFF9, 64'd2, "R6 divs -7/2", 0);
    issue(3'd2, 64'd7, 64'hFFFF_FFFE, "R6 divs 7/-2", 0);
    issue(3'd2, 64'd100, 64'd7, "R6 divs 100/7", 0);
    issue(3'd3, 64'hFFFF_FFFF, 64'd3, "R7 divu", 0);
    issue(3'd3, 64'hFFFF_FFF0, 64'd1, "R7 divu big quo", 0);
    issue(3'd3, 64'h8000_0005, 64'h10, "R7 divu rem", 0);
    issue(3'd2, 64'hFFFF_FFFB, 64'd0, "R8 divs zero neg", 0);
    issue(3'd2, 64'd9, 64'd0, "R8 divs zero pos", 0);
    issue(3'd3, 64'h9000_0000, 64'd0, "R9 divu zero", 0);
    issue(3'd2, 64'h8000_0000, 64'hFFFF_FFFF, "R10 min/-1", 0);
    issue(3'd2, 64'd1000, 64'hFFFF_FFF6, "R11 poke during divide", 1);
    repeat (4) @(posedge clk);
    #1;
    check(expQ.size() == 0, "R11 queue drained", 64'(expQ.size()), 64'd0);
    unusedOp(3'd6);
    unusedOp(3'd7);
    issue(3'd0, 64'h0001_0000, 64'h0001_0000, "R2 muls after idle", 0);
    repeat (2) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule